// File: doc/BRIEF.md
# SPI Master Port with Register Interface

This block is a synchronous serial master that software drives through a small register window. Words of up to 16 bits are written to a data register and land in an eight-entry transmit queue. A transfer engine takes them one at a time, exchanges each over a four-wire SPI bus in mode 0, or hands it straight back in loopback. The answering word goes into an eight-entry receive queue, where software reads it from the same data register.

Word size comes from a 4-bit field and is applied as a mask both when a word is queued for sending and when a word is stored as received. The engine never overruns the receive queue. It simply waits while that queue is full. Two level-triggered interrupt sources, a mask register and a read-only identification window complete the block. Slave operation and DMA requests are not provided.

Top module: `spi_master_regs`

## Requirements
- R1: After reset both queues are empty: status (0x0C) reads 0x03, raw interrupts (0x18) read 0x08, masked interrupts (0x1C) read 0, `irq` is low and `cs_n` is high.
- R2: The low 4 bits of control register 0x00 hold word size minus one. Data words are ANDed with a mask of size+1 low ones when written into the transmit queue and when stored into the receive queue.
- R3: Bit 0 of control register 0x04 selects loopback. In loopback each sent word returns as the received word in order, and the SPI pins stay idle.
- R4: Words move only while bit 1 of control register 0x04 (enable) is set. When it is clear, written words remain queued.
- R5: A write to data register 0x08 while the transmit queue holds 8 words is discarded.
- R6: A read of the data register with an empty receive queue returns 0 and changes no state.
- R7: A word is moved only while the receive queue holds fewer than 8 entries. The receive queue never exceeds 8 entries, and sending resumes after a pop.
- R8: Raw interrupt bit 2 is set while the receive queue holds 4 or more entries. Raw bit 3 is set while the transmit queue holds 4 or fewer. Register 0x1C reads raw AND mask (mask at 0x14), and `irq` is high exactly when that AND is non-zero.
- R9: In SPI mode each word is shifted MSB-first using only its configured bits. `cs_n` is low for the whole word, MOSI changes while SCLK is low, and MISO is sampled on SCLK rising edges. The SCLK period is 2*max(prescaler,2) clocks.
- R10: The prescaler register (0x10) keeps only its low 8 bits. DMA control (0x20) reads 0, and undefined offsets read 0 and ignore writes.
- R11: Reads at 0xFE0..0xFFC return, one byte per word, the sequence 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Status bits are: bit0 transmit empty, bit1 transmit not full, bit2 receive not empty, bit3 receive full, bit4 busy (transmit queue holds data, including a word being shifted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_rd | input | 1 | Read strobe, data pop occurs at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the cycle of the read |
| irq | output | 1 | Combined masked interrupt |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, low during a word |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: 16-bit words, 8-deep queues and thresholds of 4. These values bring the full-width 16-bit shift, both queues completely full at once with a stalled engine, and both interrupt thresholds within a few dozen bus cycles. A 5-bit word and a prescaler below the minimum of 2 are also exercised so that the width mask and the clamped SCLK period are both observed on the pins.

// File: rtl/spi_master_regs.sv
module spi_master_regs #(
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int AW     = 12,
  parameter int RX_LVL = 4,
  parameter int TX_LVL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          sclk,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(DW);

  logic [DW-1:0] ctl0;
  logic [3:0]    ctl1;
  logic [7:0]    presc;
  logic [3:0]    imask;
  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          shifting, sclk_q;
  logic [SW-1:0] bit_left, size_q;
  logic [DW-1:0] tx_sh, rx_sh, wmask;
  logic [7:0]    div;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb
    for (int i = 0; i < DW; i++) wmask[i] = (SW'(i) <= ctl0[SW-1:0]);

  wire a_c0 = bus_addr == AW'('h00);
  wire a_c1 = bus_addr == AW'('h04);
  wire a_dr = bus_addr == AW'('h08);
  wire a_st = bus_addr == AW'('h0C);
  wire a_ps = bus_addr == AW'('h10);
  wire a_im = bus_addr == AW'('h14);
  wire a_ri = bus_addr == AW'('h18);
  wire a_mi = bus_addr == AW'('h1C);
  wire a_id = bus_addr >= AW'('hFE0);

  wire tx_full = tx_cnt == CW'(DEPTH);
  wire rx_full = rx_cnt == CW'(DEPTH);
  wire loop    = ctl1[0];
  wire start   = ctl1[1] && !shifting && tx_cnt != 0 && !rx_full;
  wire lb_move = start && loop;
  wire [7:0] half = (presc < 8'd2) ? 8'd2 : presc;
  wire tick      = div == half - 8'd1;
  wire word_done = shifting && tick && sclk_q && bit_left == '0;

  wire tx_push = bus_wr && a_dr && !tx_full;
  wire tx_pop  = lb_move || word_done;
  wire rx_pop  = bus_rd && a_dr && rx_cnt != 0;
  wire rx_push = tx_pop;
  wire [DW-1:0] rx_in = lb_move ? tx_mem[tx_rp] : rx_sh;

  wire [4:0] status = {tx_cnt != 0, rx_full, rx_cnt != 0, !tx_full, tx_cnt == 0};
  wire [3:0] ris    = {tx_cnt <= CW'(TX_LVL), rx_cnt >= CW'(RX_LVL), 2'b00};

  assign irq  = |(ris & imask);
  assign sclk = sclk_q;
  assign cs_n = !shifting;
  assign mosi = shifting && tx_sh[size_q];

  always_comb begin
    bus_rdata = '0;
    if (a_id) begin
      case (bus_addr[4:2])
        3'd0: bus_rdata = DW'(8'h22);
        3'd1: bus_rdata = DW'(8'h10);
        3'd2: bus_rdata = DW'(8'h04);
        3'd3: bus_rdata = DW'(8'h00);
        3'd4: bus_rdata = DW'(8'h0D);
        3'd5: bus_rdata = DW'(8'hF0);
        3'd6: bus_rdata = DW'(8'h05);
        default: bus_rdata = DW'(8'hB1);
      endcase
    end
    else if (a_c0) bus_rdata = ctl0;
    else if (a_c1) bus_rdata = DW'(ctl1);
    else if (a_dr) bus_rdata = (rx_cnt != 0) ? rx_mem[rx_rp] : '0;
    else if (a_st) bus_rdata = DW'(status);
    else if (a_ps) bus_rdata = DW'(presc);
    else if (a_im) bus_rdata = DW'(imask);
    else if (a_ri) bus_rdata = DW'(ris);
    else if (a_mi) bus_rdata = DW'(ris & imask);
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata & wmask;
    if (rx_push) rx_mem[rx_wp] <= rx_in & wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0 <= '0; ctl1 <= '0; presc <= '0; imask <= '0;
      tx_rp <= '0; tx_wp <= '0; rx_rp <= '0; rx_wp <= '0;
      tx_cnt <= '0; rx_cnt <= '0;
    end else begin
      if (bus_wr && a_c0) ctl0  <= bus_wdata;
      if (bus_wr && a_c1) ctl1  <= bus_wdata[3:0];
      if (bus_wr && a_ps) presc <= bus_wdata[7:0];
      if (bus_wr && a_im) imask <= bus_wdata[3:0];
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shifting <= 1'b0; sclk_q <= 1'b0; div <= '0;
      bit_left <= '0; size_q <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (start && !loop) begin
      shifting <= 1'b1;
      sclk_q   <= 1'b0;
      div      <= '0;
      tx_sh    <= tx_mem[tx_rp];
      bit_left <= ctl0[SW-1:0];
      size_q   <= ctl0[SW-1:0];
      rx_sh    <= '0;
    end else if (shifting) begin
      if (!tick) div <= div + 8'd1;
      else begin
        div <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_sh  <= {rx_sh[DW-2:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bit_left == '0) shifting <= 1'b0;
          else begin
            bit_left <= bit_left - 1'b1;
            tx_sh    <= {tx_sh[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  p_rx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH)) else $error("rx queue over depth");

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !shifting) else $error("shifting with full rx queue");

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && a_dr && tx_full && !tx_pop) |=> tx_full) else $error("full write changed count");

  p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl1[1] && !shifting) |=> $stable(tx_rp)) else $error("word moved while disabled");

  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk) else $error("sclk active without select");

  p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && a_dr && rx_cnt == 0) |-> bus_rdata == '0) else $error("empty read nonzero");

  p_irq_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt >= CW'(RX_LVL) && imask[2]) |-> irq) else $error("rx interrupt missing");
endmodule

// File: tb/spi_master_regs_test.sv
`timescale 1ns/1ps
module spi_master_regs_test;
  logic clk = 0;
  always #5 clk = ~clk;
  logic rst_n = 0, bus_rd = 0, bus_wr = 0, miso = 0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq, sclk, cs_n, mosi;

  spi_master_regs uut (.clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int checks = 0, fails = 0;
  int exp_rx[$], mosi_q[$], slave_q[$];
  int cur_bits = 16;
  longint exp_period = 40;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); bus_wr = 1; bus_addr = 12'(a); bus_wdata = 16'(d);
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); bus_rd = 1; bus_addr = 12'(a);
    #1 d = int'(bus_rdata);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rd_chk(string req, int a, int exp);
    int d;
    rd(a, d); chk(req, d, exp);
  endtask

  task automatic send(int d, int masked);
    exp_rx.push_back(masked);
    wr('h08, d);
  endtask

  task automatic pop_chk(string req);
    int d, e;
    e = exp_rx.size() != 0 ? exp_rx.pop_front() : 0;
    rd('h08, d); chk(req, d, e);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int s;
    for (int k = 0; k < 1000; k++) begin
      rd('h0C, s);
      if (s[4] == 0) break;
    end
    settle(2);
  endtask

  // SPI slave: drives MISO MSB-first, changes on SCLK falling edges
  initial begin
    logic [15:0] sh;
    forever begin
      @(negedge cs_n);
      sh = slave_q.size() != 0 ? 16'(slave_q.pop_front()) : 16'h0;
      sh = sh << (16 - cur_bits);
      miso = sh[15];
      while (!cs_n) begin
        @(negedge sclk or posedge cs_n);
        if (!cs_n) begin sh = sh << 1; miso = sh[15]; end
      end
    end
  end

  // Monitor: collects MOSI per word and compares with the expected queue
  initial begin
    logic [15:0] word;
    int bits;
    longint t0, t1;
    forever begin
      @(negedge cs_n);
      word = 0; bits = 0; t0 = 0; t1 = 0;
      while (!cs_n) begin
        @(posedge sclk or posedge cs_n);
        if (!cs_n) begin
          word = {word[14:0], mosi};
          bits++;
          if (bits == 1) t0 = $time;
          if (bits == 2) t1 = $time;
        end
      end
      chk("R9 mosi word", int'(word), mosi_q.size() != 0 ? mosi_q.pop_front() : -1);
      chk("R9 bit count", bits, cur_bits);
      chk("R9 sclk period", int'(t1 - t0), int'(exp_period));
    end
  end

  task automatic run_all();
    int id_tab[8] = '{'h22, 'h10, 'h04, 'h00, 'h0D, 'hF0, 'h05, 'hB1};
    settle(3); rst_n = 1; settle(1);
    // R1 reset state
    rd_chk("R1 status", 'h0C, 'h03);
    rd_chk("R1 raw irq", 'h18, 'h08);
    rd_chk("R1 masked irq", 'h1C, 0);
    chk("R1 irq pin", int'(irq), 0);
    chk("R1 cs_n", int'(cs_n), 1);
    // R11 id window
    for (int i = 0; i < 8; i++) rd_chk("R11 id byte", 'hFE0 + 4 * i, id_tab[i]);
    // R10 prescaler width, DMA, undefined offset
    wr('h10, 'h1234); rd_chk("R10 prescaler", 'h10, 'h34);
    wr('h20, 1); rd_chk("R10 dma reads zero", 'h20, 0);
    wr('h24, 'hFFFF); rd_chk("R10 undefined read", 'h24, 0);
    rd_chk("R10 ctl0 untouched", 'h00, 0);
    // R2 / R3 loopback with 8-bit mask
    wr('h00, 7); wr('h04, 3);
    send('hABCD, 'hCD); send('h1234, 'h34);
    settle(3);
    chk("R3 pins idle", int'(cs_n), 1);
    pop_chk("R2 masked loopback word");
    pop_chk("R3 loopback order");
    // R4 disabled
    wr('h04, 1); wr('h00, 'hF);
    send('h1111, 'h1111); send('h2222, 'h2222);
    settle(5);
    rd_chk("R4 status while disabled", 'h0C, 'h12);
    rd_chk("R4 raw irq while disabled", 'h18, 'h08);
    wr('h04, 3); settle(4);
    rd_chk("R12 status rx only", 'h0C, 'h07);
    pop_chk("R4 first word after enable");
    pop_chk("R4 second word after enable");
    // R7 / R5 / R8 / R12 full queues
    wr('h14, 'h0C);
    for (int i = 0; i < 16; i++) send(i * 'h0101 + 1, i * 'h0101 + 1);
    wr('h08, 'hDEAD);
    settle(4);
    rd_chk("R12 status both full", 'h0C, 'h1C);
    rd_chk("R8 raw with rx high", 'h18, 'h04);
    rd_chk("R8 masked", 'h1C, 'h04);
    chk("R8 irq high", int'(irq), 1);
    wr('h14, 'h08);
    rd_chk("R8 masked rx off", 'h1C, 0);
    chk("R8 irq low", int'(irq), 0);
    for (int i = 0; i < 4; i++) pop_chk("R7 drain after stall");
    settle(4);
    rd_chk("R8 raw both sources", 'h18, 'h0C);
    chk("R8 tx level irq", int'(irq), 1);
    for (int i = 0; i < 12; i++) pop_chk("R5 R7 drain, full write dropped");
    rd_chk("R6 empty read", 'h08, 0);
    rd_chk("R6 status after empty read", 'h0C, 'h03);
    // R9 SPI 16-bit, prescaler 3
    wr('h04, 2); wr('h10, 3); exp_period = 60; cur_bits = 16;
    slave_q.push_back('h5A3C); mosi_q.push_back('hC3A5);
    send('hC3A5, 'h5A3C);
    wait_idle();
    chk("R9 cs_n idle", int'(cs_n), 1);
    pop_chk("R9 received word");
    // R9 5-bit word, prescaler clamped to 2
    wr('h10, 0); exp_period = 40; wr('h00, 4); cur_bits = 5;
    slave_q.push_back('h0A); mosi_q.push_back('h13);
    send('h1F3, 'h0A);
    wait_idle();
    pop_chk("R2 R9 5-bit received word");
    chk("R9 all words seen", mosi_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule